// File: doc/BRIEF.md
# PTP Slave Clock Offset Corrector

This block sits on the slave side of a precision-time synchronization exchange. Upstream logic parses the frames. It hands the block one-cycle strobes for Sync, Follow_Up and Announce messages, each with its sequence identifier. A Sync strobe carries the seconds/nanoseconds receive timestamp taken by the local clock (t5). A Follow_Up strobe carries the origin timestamp stamped by the master. A separate input holds the most recent peer-delay measurement in nanoseconds.

A Follow_Up is accepted only when its identifier matches the pending Sync. On acceptance the block adds the peer delay to the origin time to form t6, wrapping nanoseconds into seconds. It then takes t6 minus t5 in nanoseconds and emits a single-cycle adjust command for the local timer. The command is a direction flag (0 = add, 1 = subtract) and a 30-bit magnitude. An offset that does not fit the magnitude field is flagged and produces no command.

Two countdown supervisors, one for Sync and one for Announce, count reference ticks. A request to take the master role is raised whenever either supervisor runs dry.

Top module: `ptp_offset_corrector`

## Requirements
- R1: A Sync strobe stores its sequence identifier and receive timestamp as the pending t5, and `sync_evt` is high for exactly the one cycle after the cycle in which `sync_vld` was sampled high.
- R2: A Follow_Up strobe never causes `sync_evt` to rise.
- R3: A Follow_Up is accepted only when a Sync is pending and `fup_seq` equals the pending identifier. A mismatching Follow_Up is discarded and the pending Sync is kept. A Follow_Up with nothing pending is ignored. Acceptance clears the pending Sync. A new Sync overwrites a pending, unpaired one.
- R4: t6 is the Follow_Up origin time plus `peer_delay_ns`. Nanosecond inputs are below 1,000,000,000. A nanosecond sum of one billion or more subtracts one billion and adds one to the seconds.
- R5: The offset is (t6 − t5) in nanoseconds, with seconds weighted by one billion. The result of an accepted Follow_Up sampled at clock edge k appears on the outputs after edge k+1 and lasts exactly one cycle.
- R6: `adj_dir` is 0 when t6 > t5 and 1 otherwise, and `adj_mag` is |t6 − t5|. Equal times give `adj_dir` = 1 and `adj_mag` = 0.
- R7: When |t6 − t5| exceeds 2^30 − 1, `adj_oor` pulses in place of `adj_vld`, and `adj_vld` stays low for that Follow_Up.
- R8: Each supervisor loads its limit in the first cycle after reset and reloads it on every strobe of its message type (Sync or Announce). Otherwise it decrements by one on each cycle with `tick` high and holds at zero.
- R9: `become_master` is high exactly while either supervisor holds zero after its first load. It falls only through a reload of the exhausted supervisor(s).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Reference timeout tick |
| sync_vld | input | 1 | Sync message strobe |
| sync_seq | input | 16 | Sync sequence identifier |
| sync_sec | input | 48 | Sync receive time, seconds |
| sync_ns | input | 30 | Sync receive time, nanoseconds |
| fup_vld | input | 1 | Follow_Up message strobe |
| fup_seq | input | 16 | Follow_Up sequence identifier |
| fup_sec | input | 48 | Origin time, seconds |
| fup_ns | input | 30 | Origin time, nanoseconds |
| ann_vld | input | 1 | Announce message strobe |
| peer_delay_ns | input | 30 | Measured peer delay, nanoseconds |
| sync_to_limit | input | 16 | Sync timeout in ticks |
| ann_to_limit | input | 16 | Announce timeout in ticks |
| sync_evt | output | 1 | Sync received event pulse |
| adj_vld | output | 1 | Timer adjust command valid |
| adj_dir | output | 1 | 0 = add, 1 = subtract |
| adj_mag | output | 30 | Adjust magnitude, nanoseconds |
| adj_oor | output | 1 | Offset out of range pulse |
| become_master | output | 1 | Request to take the master role |

## Verification
A stale or wrongly cleared pending Sync shows up two cycles after the next Follow_Up. The symptom is either a missing `adj_vld` pulse or an extra one, or a magnitude computed against the wrong t5. A dropped nanosecond carry or a seconds weighting error changes `adj_mag` by about a billion or flips the range flag on that same pulse. A supervisor that reloads or decrements wrongly moves the rising edge of `become_master` by at least one tick period. The bench compares every output against a behavioural model on every cycle, so each of these faults is caught in the first cycle it becomes visible.

// File: rtl/ptp_pkg.sv
package ptp_pkg;
  localparam int unsigned NS_PER_SEC = 32'd1_000_000_000;

  typedef enum logic {
    ADJ_ADD = 1'b0,
    ADJ_SUB = 1'b1
  } adj_dir_e;
endpackage

// File: rtl/ptp_sync_pairer.sv
module ptp_sync_pairer #(
  parameter int SEC_W = 48,
  parameter int NS_W  = 30,
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_vld,
  input  logic [SEQ_W-1:0] sync_seq,
  input  logic [SEC_W-1:0] sync_sec,
  input  logic [NS_W-1:0]  sync_ns,
  input  logic             fup_vld,
  input  logic [SEQ_W-1:0] fup_seq,
  output logic             sync_evt,
  output logic             pair_hit,
  output logic [SEC_W-1:0] t5_sec,
  output logic [NS_W-1:0]  t5_ns
);
  logic             pend_q, pend_d;
  logic [SEQ_W-1:0] seq_q, seq_d;
  logic [SEC_W-1:0] sec_q, sec_d;
  logic [NS_W-1:0]  ns_q, ns_d;
  logic             evt_q;
  logic             load_en;

  assign pair_hit = fup_vld & pend_q & (fup_seq == seq_q);
  assign load_en  = sync_vld;

  always_comb begin
    pend_d = pend_q;
    seq_d  = seq_q;
    sec_d  = sec_q;
    ns_d   = ns_q;
    if (load_en) begin
      pend_d = 1'b1;
      seq_d  = sync_seq;
      sec_d  = sync_sec;
      ns_d   = sync_ns;
    end else if (pair_hit) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      seq_q  <= '0;
      sec_q  <= '0;
      ns_q   <= '0;
      evt_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      evt_q  <= sync_vld;
      if (load_en) begin
        seq_q <= seq_d;
        sec_q <= sec_d;
        ns_q  <= ns_d;
      end
    end
  end

  assign sync_evt = evt_q;
  assign t5_sec   = sec_q;
  assign t5_ns    = ns_q;

  AST_EVT_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    sync_vld |=> sync_evt); // R1
  AST_NO_EVT_FUP: assert property (@(posedge clk) disable iff (!rst_n)
    (fup_vld && !sync_vld) |=> !sync_evt); // R2
  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_hit && !sync_vld) |=> !pend_q); // R3
endmodule

// File: rtl/ptp_offset_calc.sv
module ptp_offset_calc #(
  parameter int SEC_W = 48,
  parameter int NS_W  = 30,
  parameter int MAG_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_hit,
  input  logic [SEC_W-1:0] t5_sec,
  input  logic [NS_W-1:0]  t5_ns,
  input  logic [SEC_W-1:0] org_sec,
  input  logic [NS_W-1:0]  org_ns,
  input  logic [NS_W-1:0]  peer_delay,
  output logic             adj_vld,
  output logic             adj_dir,
  output logic [MAG_W-1:0] adj_mag,
  output logic             adj_oor
);
  import ptp_pkg::*;

  localparam int DW = SEC_W + NS_W + 4;
  localparam logic [NS_W:0]          NSPS_N = (NS_W+1)'(NS_PER_SEC);
  localparam logic signed [DW-1:0]   NSPS_D = DW'(NS_PER_SEC);

  // stage 1: t6 = origin + peer delay, with nanosecond wrap
  logic [NS_W:0]     ns_sum, ns_wrap;
  logic              carry;
  logic [SEC_W-1:0]  t6_sec_d;
  logic [NS_W-1:0]   t6_ns_d;

  always_comb begin
    ns_sum   = {1'b0, org_ns} + {1'b0, peer_delay};
    carry    = (ns_sum >= NSPS_N);
    ns_wrap  = carry ? (ns_sum - NSPS_N) : ns_sum;
    t6_ns_d  = ns_wrap[NS_W-1:0];
    t6_sec_d = org_sec + SEC_W'(carry);
  end

  logic              s1_vld_q;
  logic [SEC_W-1:0]  s1_t6_sec_q, s1_t5_sec_q;
  logic [NS_W-1:0]   s1_t6_ns_q, s1_t5_ns_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q    <= 1'b0;
      s1_t6_sec_q <= '0;
      s1_t6_ns_q  <= '0;
      s1_t5_sec_q <= '0;
      s1_t5_ns_q  <= '0;
    end else begin
      s1_vld_q <= pair_hit;
      if (pair_hit) begin
        s1_t6_sec_q <= t6_sec_d;
        s1_t6_ns_q  <= t6_ns_d;
        s1_t5_sec_q <= t5_sec;
        s1_t5_ns_q  <= t5_ns;
      end
    end
  end

  // stage 2: signed nanosecond difference, magnitude and range
  logic signed [SEC_W:0]  sec_diff;
  logic signed [NS_W:0]   ns_diff;
  logic signed [DW-1:0]   sec_part, ns_part, total, abs_val;
  logic                   is_pos, oor_d;
  logic [MAG_W-1:0]       mag_d;
  adj_dir_e               dir_d;

  always_comb begin
    sec_diff = $signed({1'b0, s1_t6_sec_q}) - $signed({1'b0, s1_t5_sec_q});
    ns_diff  = $signed({1'b0, s1_t6_ns_q}) - $signed({1'b0, s1_t5_ns_q});
    sec_part = {{(DW-SEC_W-1){sec_diff[SEC_W]}}, sec_diff} * NSPS_D;
    ns_part  = {{(DW-NS_W-1){ns_diff[NS_W]}}, ns_diff};
    total    = sec_part + ns_part;
    is_pos   = !total[DW-1] && (total != '0);
    abs_val  = total[DW-1] ? -total : total;
    oor_d    = |abs_val[DW-1:MAG_W];
    mag_d    = abs_val[MAG_W-1:0];
    dir_d    = is_pos ? ADJ_ADD : ADJ_SUB;
  end

  logic             vld_q, oor_q, dir_q;
  logic [MAG_W-1:0] mag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      oor_q <= 1'b0;
      dir_q <= 1'b0;
      mag_q <= '0;
    end else begin
      vld_q <= s1_vld_q & ~oor_d;
      oor_q <= s1_vld_q & oor_d;
      if (s1_vld_q) begin
        dir_q <= dir_d;
        mag_q <= mag_d;
      end
    end
  end

  assign adj_vld = vld_q;
  assign adj_oor = oor_q;
  assign adj_dir = dir_q;
  assign adj_mag = mag_q;

  AST_T6_NS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld_q |-> (s1_t6_ns_q < NSPS_N[NS_W-1:0])); // R4
  AST_OUT_FROM_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_vld || adj_oor) |-> $past(s1_vld_q)); // R5
  AST_ZERO_IS_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_vld && adj_mag == '0) |-> adj_dir); // R6
  AST_OOR_NO_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
    adj_oor |-> !adj_vld); // R7
endmodule

// File: rtl/ptp_timeout_watch.sv
module ptp_timeout_watch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             msg,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic             arm_q, arm_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    arm_d  = 1'b1;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!arm_q || msg) begin
      cnt_d  = limit;
      cnt_en = 1'b1;
    end else if (tick && cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      arm_q <= arm_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign expired = arm_q & (cnt_q == '0);

  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && msg) |=> (cnt_q == $past(limit))); // R8
  AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && !msg) |=> (cnt_q <= $past(cnt_q))); // R8
endmodule

// File: rtl/ptp_offset_corrector.sv
module ptp_offset_corrector #(
  parameter int SEC_W = 48,
  parameter int NS_W  = 30,
  parameter int SEQ_W = 16,
  parameter int MAG_W = 30,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sync_vld,
  input  logic [SEQ_W-1:0] sync_seq,
  input  logic [SEC_W-1:0] sync_sec,
  input  logic [NS_W-1:0]  sync_ns,
  input  logic             fup_vld,
  input  logic [SEQ_W-1:0] fup_seq,
  input  logic [SEC_W-1:0] fup_sec,
  input  logic [NS_W-1:0]  fup_ns,
  input  logic             ann_vld,
  input  logic [NS_W-1:0]  peer_delay_ns,
  input  logic [TO_W-1:0]  sync_to_limit,
  input  logic [TO_W-1:0]  ann_to_limit,
  output logic             sync_evt,
  output logic             adj_vld,
  output logic             adj_dir,
  output logic [MAG_W-1:0] adj_mag,
  output logic             adj_oor,
  output logic             become_master
);
  localparam int N_WATCH = 2;

  logic             pair_hit;
  logic [SEC_W-1:0] t5_sec;
  logic [NS_W-1:0]  t5_ns;

  ptp_sync_pairer #(.SEC_W(SEC_W), .NS_W(NS_W), .SEQ_W(SEQ_W)) u_pair (
    .clk(clk), .rst_n(rst_n),
    .sync_vld(sync_vld), .sync_seq(sync_seq), .sync_sec(sync_sec), .sync_ns(sync_ns),
    .fup_vld(fup_vld), .fup_seq(fup_seq),
    .sync_evt(sync_evt), .pair_hit(pair_hit), .t5_sec(t5_sec), .t5_ns(t5_ns)
  );

  ptp_offset_calc #(.SEC_W(SEC_W), .NS_W(NS_W), .MAG_W(MAG_W)) u_calc (
    .clk(clk), .rst_n(rst_n), .pair_hit(pair_hit),
    .t5_sec(t5_sec), .t5_ns(t5_ns), .org_sec(fup_sec), .org_ns(fup_ns),
    .peer_delay(peer_delay_ns),
    .adj_vld(adj_vld), .adj_dir(adj_dir), .adj_mag(adj_mag), .adj_oor(adj_oor)
  );

  logic [N_WATCH-1:0] msg_v;
  logic [TO_W-1:0]    lim_v [N_WATCH];
  logic [N_WATCH-1:0] exp_v;

  assign msg_v[0] = sync_vld;
  assign msg_v[1] = ann_vld;
  assign lim_v[0] = sync_to_limit;
  assign lim_v[1] = ann_to_limit;

  for (genvar g = 0; g < N_WATCH; g++) begin : g_watch
    ptp_timeout_watch #(.CNT_W(TO_W)) u_watch (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .msg(msg_v[g]), .limit(lim_v[g]), .expired(exp_v[g])
    );
  end

  assign become_master = |exp_v;

  AST_MASTER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (become_master && !sync_vld && !ann_vld) |=> become_master); // R9
endmodule

// File: tb/ptp_offset_corrector_bench.sv
module ptp_offset_corrector_bench;
  localparam int SEC_W = 48, NS_W = 30, SEQ_W = 16, MAG_W = 30, TO_W = 16;
  localparam longint BIL = 64'd1_000_000_000;
  localparam longint MAGMAX = (64'd1 << MAG_W) - 1;
  localparam int SYNC_LIM = 12, ANN_LIM = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic sync_vld = 1'b0, fup_vld = 1'b0, ann_vld = 1'b0;
  logic [SEQ_W-1:0] sync_seq = '0, fup_seq = '0;
  logic [SEC_W-1:0] sync_sec = '0, fup_sec = '0;
  logic [NS_W-1:0]  sync_ns = '0, fup_ns = '0, peer_delay_ns = '0;
  logic [TO_W-1:0]  sync_to_limit = TO_W'(SYNC_LIM), ann_to_limit = TO_W'(ANN_LIM);
  logic sync_evt, adj_vld, adj_dir, adj_oor, become_master;
  logic [MAG_W-1:0] adj_mag;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ptp_offset_corrector u_ptp_offset_corrector (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .sync_vld(sync_vld), .sync_seq(sync_seq), .sync_sec(sync_sec), .sync_ns(sync_ns),
    .fup_vld(fup_vld), .fup_seq(fup_seq), .fup_sec(fup_sec), .fup_ns(fup_ns),
    .ann_vld(ann_vld), .peer_delay_ns(peer_delay_ns),
    .sync_to_limit(sync_to_limit), .ann_to_limit(ann_to_limit),
    .sync_evt(sync_evt), .adj_vld(adj_vld), .adj_dir(adj_dir), .adj_mag(adj_mag),
    .adj_oor(adj_oor), .become_master(become_master)
  );

  // behavioural reference model
  bit     m_pend, m_evt;
  int     m_pseq;
  longint m_t5;
  bit     a_vld, a_oor, a_dir, b_vld, b_oor, b_dir;
  longint a_mag, b_mag;
  bit     s_arm, n_arm;
  int     s_cnt, n_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_evt = 0; m_pseq = 0; m_t5 = 0;
      a_vld = 0; a_oor = 0; a_dir = 0; a_mag = 0;
      b_vld = 0; b_oor = 0; b_dir = 0; b_mag = 0;
      s_arm = 0; n_arm = 0; s_cnt = 0; n_cnt = 0;
    end else begin
      bit hit;
      longint t6, off;
      hit = fup_vld && m_pend && (int'(fup_seq) == m_pseq);
      b_vld = a_vld; b_oor = a_oor; b_dir = a_dir; b_mag = a_mag;
      a_vld = hit;
      if (hit) begin
        t6 = longint'(fup_sec) * BIL + longint'(fup_ns) + longint'(peer_delay_ns);
        off = t6 - m_t5;
        a_dir = !(off > 0);
        a_mag = (off < 0) ? -off : off;
        a_oor = a_mag > MAGMAX;
      end
      m_evt = sync_vld;
      if (sync_vld) begin
        m_pend = 1; m_pseq = int'(sync_seq);
        m_t5 = longint'(sync_sec) * BIL + longint'(sync_ns);
      end else if (hit) m_pend = 0;
      if (!s_arm || sync_vld) s_cnt = SYNC_LIM;
      else if (tick && s_cnt > 0) s_cnt--;
      if (!n_arm || ann_vld) n_cnt = ANN_LIM;
      else if (tick && n_cnt > 0) n_cnt--;
      s_arm = 1; n_arm = 1;
    end
  end

  task automatic chk(input bit cond, input string req, input longint act, input longint exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // compare away from the active edge; drive tick here too
  always @(negedge clk) begin
    cyc++;
    tick <= (cyc % 4 == 3);
    if (!done) begin
      if (!rst_n) begin
        chk(adj_vld == 0 && adj_oor == 0, "R5 reset adj", adj_vld, 0);
        chk(sync_evt == 0, "R1 reset evt", sync_evt, 0);
        chk(become_master == 0, "R9 reset master", become_master, 0);
      end else begin
        bit ev, eo, em;
        ev = b_vld && !b_oor;
        eo = b_vld && b_oor;
        em = (s_arm && s_cnt == 0) || (n_arm && n_cnt == 0);
        chk(sync_evt == m_evt, "R1 R2 sync_evt", sync_evt, m_evt);
        chk(adj_vld == ev, "R3 R5 adj_vld", adj_vld, ev);
        chk(adj_oor == eo, "R7 adj_oor", adj_oor, eo);
        if (ev) begin
          chk(adj_dir == b_dir, "R6 adj_dir", adj_dir, b_dir);
          chk(longint'(adj_mag) == b_mag, "R4 R6 adj_mag", adj_mag, b_mag);
        end
        chk(become_master == em, "R8 R9 become_master", become_master, em);
      end
    end
    if (cyc > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_sync(input int seq, input longint sec, input longint ns, input bit ann);
    @(negedge clk);
    sync_vld = 1; ann_vld = ann;
    sync_seq = SEQ_W'(seq); sync_sec = SEC_W'(sec); sync_ns = NS_W'(ns);
    @(negedge clk);
    sync_vld = 0; ann_vld = 0;
  endtask

  task automatic send_fup(input int seq, input longint sec, input longint ns, input longint pd);
    @(negedge clk);
    fup_vld = 1; fup_seq = SEQ_W'(seq); fup_sec = SEC_W'(sec); fup_ns = NS_W'(ns);
    peer_delay_ns = NS_W'(pd);
    @(negedge clk);
    fup_vld = 0;
  endtask

  initial begin
    idle(4);
    rst_n = 1;
    idle(3);
    // R6 negative offset: subtract 300
    send_sync(5, 100, 500_000_000, 1);  idle(2);
    send_fup(5, 100, 499_999_000, 700); idle(4);
    // R6 positive offset: add 950
    send_sync(6, 200, 100, 1);          idle(1);
    send_fup(6, 200, 50, 1000);         idle(4);
    // R4 nanosecond wrap with carry into seconds
    send_sync(7, 301, 200, 1);
    send_fup(7, 300, 999_999_900, 500); idle(4);
    // R6 equal times: direction 1, magnitude 0
    send_sync(8, 400, 1000, 1);
    send_fup(8, 400, 900, 100);         idle(4);
    // R3 mismatching identifier discarded, pending kept
    send_sync(9, 450, 10, 1);
    send_fup(3, 450, 20, 0);            idle(3);
    send_fup(9, 450, 20, 0);            idle(3);
    // R3 no pending Sync: ignored
    send_fup(9, 450, 20, 0);            idle(4);
    // R3 replacement: older identifier no longer pairs
    send_sync(10, 460, 0, 1);
    send_sync(11, 470, 0, 1);
    send_fup(10, 460, 5, 0);            idle(2);
    send_fup(11, 470, 77, 0);           idle(4);
    // R7 out of range: two seconds
    send_sync(12, 500, 0, 1);
    send_fup(12, 502, 0, 0);            idle(4);
    // R6 one second behind fits the field
    send_sync(13, 600, 0, 1);
    send_fup(13, 599, 0, 0);            idle(4);
    // R8 R9: let both supervisors run dry
    idle(100);
    // R9 announce alone leaves the sync supervisor exhausted
    @(negedge clk); ann_vld = 1; @(negedge clk); ann_vld = 0;
    idle(3);
    send_sync(14, 700, 0, 0);           idle(6);
    @(negedge clk); ann_vld = 1; @(negedge clk); ann_vld = 0;
    idle(6);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule